// File: doc/BRIEF.md
# Warp Memory Access Coalescer

This block converts one warp memory instruction into a sequence of line-sized memory transactions. A start pulse delivers a per-lane active mask, one byte address per lane, the access size in bytes, a memory-space code and a write flag. The space code picks the line size. The block then groups the active lanes by their line-aligned address and sends one transaction for each distinct line over a ready/valid stream.

Each transaction carries the line address, the line size, the write flag, the mask of lanes that fall in that line and a byte mask. The byte mask is built once from all active lanes and is the same on every transaction of the instruction. Lines leave in ascending address order. A space that maps to a zero line size produces no transactions. The block accepts no new instruction until the current one is finished, and it marks the finish with a one-cycle done pulse.

Top module: `warp_coalescer`

## Requirements
- R1: Space code 1 (texture) selects a line size of TEX_LINE bytes, which appears on `txn_line_size`.
- R2: Space codes 2 (constant) and 3 (kernel parameter) select a line size of CONST_LINE bytes.
- R3: Space code 0 selects a line size of zero. The instruction then emits no transaction, and `done` pulses in the cycle after the start.
- R4: A lane whose `lane_active` bit is clear contributes to no lane mask, no byte mask and no line.
- R5: The line address of a lane is its byte address with the low log2(line size) bits cleared. Lane i's address is `lane_addr[i*AW +: AW]`.
- R6: Each distinct line address of the active lanes produces exactly one transaction. Bit i of its lane mask is set exactly when lane i is active and maps to that line.
- R7: The byte mask is the OR over all active lanes of bits offset .. offset+size-1, where offset is the address minus the line address. Bits at MASK_W or above are dropped. Every transaction of the instruction carries this same mask.
- R8: The transactions of one instruction leave in strictly ascending line-address order.
- R9: While `txn_valid` is high and `txn_ready` is low, `txn_valid` and all transaction fields hold their values.
- R10: `done` is high for exactly one cycle. It comes in the cycle after the handshake of the last transaction, and `busy` is low in that cycle.
- R11: A start pulse while `busy` is high is ignored. The running instruction's transactions are unchanged by it.
- R12: If no lane is active, the block emits no transaction and pulses `done` in the cycle after the start.
- R13: After reset, `busy`, `done` and `txn_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Launches an instruction when the block is not busy |
| lane_active | input | LANES | Active bit per lane |
| lane_addr | input | LANES*AW | Byte address per lane, lane i at bits i*AW and up |
| acc_size | input | SZW | Bytes accessed per lane |
| space | input | 2 | 0 other, 1 texture, 2 constant, 3 kernel parameter |
| is_write | input | 1 | Write flag copied into each transaction |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | One-cycle pulse when an instruction is finished |
| txn_valid | output | 1 | Transaction available |
| txn_ready | input | 1 | Consumer accepts the transaction |
| txn_line_addr | output | AW | Aligned line address |
| txn_line_size | output | LSW | Line size in bytes |
| txn_write | output | 1 | Write flag |
| txn_lane_mask | output | LANES | Lanes served by this line |
| txn_byte_mask | output | MASK_W | Bytes touched by the instruction |

## Verification
Contiguous unit-stride lanes tell the texture line size apart from the constant line size, because the same addresses split into two lines for one and four lines for the other. Descending and scattered addresses show whether lines are sorted rather than emitted in lane order. Sparse active masks whose inactive lanes point at their own lines reveal any leak from inactive lanes. A zero-size space, an empty mask, an access that crosses a line end, a start while busy and random ready stalls cover the edge cases. Random address clusters then mix shared and private lines.

// File: rtl/warp_coalescer.sv
module warp_coalescer #(
  parameter int LANES      = 32,
  parameter int AW         = 32,
  parameter int SZW        = 5,
  parameter int MASK_W     = 256,
  parameter int TEX_LINE   = 64,
  parameter int CONST_LINE = 32,
  localparam int LSW       = $clog2(MASK_W) + 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [LANES-1:0]      lane_active,
  input  logic [LANES*AW-1:0]   lane_addr,
  input  logic [SZW-1:0]        acc_size,
  input  logic [1:0]            space,
  input  logic                  is_write,
  output logic                  busy,
  output logic                  done,
  output logic                  txn_valid,
  input  logic                  txn_ready,
  output logic [AW-1:0]         txn_line_addr,
  output logic [LSW-1:0]        txn_line_size,
  output logic                  txn_write,
  output logic [LANES-1:0]      txn_lane_mask,
  output logic [MASK_W-1:0]     txn_byte_mask
);

  localparam logic [1:0] SP_TEX   = 2'd1;
  localparam logic [1:0] SP_CONST = 2'd2;
  localparam logic [1:0] SP_PARAM = 2'd3;

  logic [AW-1:0]    addr_q [LANES];
  logic [LANES-1:0] act_q, pend_q;
  logic [SZW-1:0]   size_q;
  logic [LSW-1:0]   lsz_q, sel_lsz;
  logic             wr_q;

  always_comb begin
    case (space)
      SP_TEX:             sel_lsz = LSW'(TEX_LINE);
      SP_CONST, SP_PARAM: sel_lsz = LSW'(CONST_LINE);
      default:            sel_lsz = '0;
    endcase
  end

  wire [AW-1:0] off_msk = AW'(lsz_q) - AW'(1);

  logic [AW-1:0] la [LANES];
  always_comb
    for (int i = 0; i < LANES; i++) la[i] = addr_q[i] & ~off_msk;

  logic [AW-1:0]    best;
  logic             found;
  logic [LANES-1:0] grp;
  always_comb begin
    best  = '0;
    found = 1'b0;
    for (int i = 0; i < LANES; i++)
      if (pend_q[i] && (!found || la[i] < best)) begin
        best  = la[i];
        found = 1'b1;
      end
    for (int i = 0; i < LANES; i++) grp[i] = pend_q[i] && (la[i] == best);
  end

  logic [MASK_W-1:0] bmask;
  always_comb begin
    bmask = '0;
    for (int i = 0; i < LANES; i++)
      if (act_q[i])
        bmask |= (~({MASK_W{1'b1}} << size_q)) << (addr_q[i] & off_msk);
  end

  wire              fire = busy && txn_ready;
  wire [LANES-1:0]  rem  = pend_q & ~grp;
  wire              take = start && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      pend_q <= '0;
      act_q  <= '0;
      size_q <= '0;
      lsz_q  <= '0;
      wr_q   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (take) begin
        act_q  <= lane_active;
        size_q <= acc_size;
        lsz_q  <= sel_lsz;
        wr_q   <= is_write;
        pend_q <= (sel_lsz != '0) ? lane_active : '0;
        if (sel_lsz == '0 || lane_active == '0) done <= 1'b1;
        else                                     busy <= 1'b1;
      end else if (fire) begin
        pend_q <= rem;
        if (rem == '0) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk)
    if (take)
      for (int i = 0; i < LANES; i++) addr_q[i] <= lane_addr[i*AW +: AW];

  assign txn_valid     = busy;
  assign txn_line_addr = best;
  assign txn_line_size = lsz_q;
  assign txn_write     = wr_q;
  assign txn_lane_mask = grp;
  assign txn_byte_mask = bmask;

endmodule

// File: rtl/warp_coalescer_chk.sv
module warp_coalescer_chk #(
  parameter int LANES      = 32,
  parameter int AW         = 32,
  parameter int MASK_W     = 256,
  parameter int TEX_LINE   = 64,
  parameter int CONST_LINE = 32,
  localparam int LSW       = $clog2(MASK_W) + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              txn_valid,
  input logic              txn_ready,
  input logic [AW-1:0]     txn_line_addr,
  input logic [LSW-1:0]    txn_line_size,
  input logic              txn_write,
  input logic [LANES-1:0]  txn_lane_mask,
  input logic [MASK_W-1:0] txn_byte_mask
);

  // R1, R2
  p_line_size_r1: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid |-> (txn_line_size == LSW'(TEX_LINE) || txn_line_size == LSW'(CONST_LINE)));

  p_align_r5: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid |-> ((txn_line_addr & (AW'(txn_line_size) - AW'(1))) == '0));

  p_lanes_r6: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid |-> (txn_lane_mask != '0));

  p_ascend_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_valid && txn_ready) |=> (!txn_valid || txn_line_addr > $past(txn_line_addr)));

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_valid && !txn_ready) |=> (txn_valid && $stable(txn_line_addr) && $stable(txn_lane_mask)
                                   && $stable(txn_byte_mask) && $stable(txn_write)
                                   && $stable(txn_line_size)));

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !txn_valid));

endmodule

bind warp_coalescer warp_coalescer_chk #(
  .LANES(LANES), .AW(AW), .MASK_W(MASK_W), .TEX_LINE(TEX_LINE), .CONST_LINE(CONST_LINE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .txn_valid(txn_valid),
  .txn_ready(txn_ready), .txn_line_addr(txn_line_addr), .txn_line_size(txn_line_size),
  .txn_write(txn_write), .txn_lane_mask(txn_lane_mask), .txn_byte_mask(txn_byte_mask)
);

// File: tb/warp_coalescer_tb.sv
module warp_coalescer_tb;
  localparam int LANES = 32, AW = 32, SZW = 5, MASK_W = 256, TEXL = 64, CONSTL = 32;
  localparam int LSW = $clog2(MASK_W) + 1;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, is_write = 1'b0, txn_ready = 1'b1;
  logic [LANES-1:0] lane_active = '0;
  logic [LANES*AW-1:0] lane_addr = '0;
  logic [SZW-1:0] acc_size = '0;
  logic [1:0] space = '0;
  logic busy, done, txn_valid, txn_write;
  logic [AW-1:0] txn_line_addr;
  logic [LSW-1:0] txn_line_size;
  logic [LANES-1:0] txn_lane_mask;
  logic [MASK_W-1:0] txn_byte_mask;

  always #5 clk = ~clk;

  warp_coalescer u_dut (.*);

  int vectors = 0, miscompares = 0, cyc = 0;
  string cur_req = "R13";
  bit bp_en = 1'b0;

  logic [AW-1:0] ql[$];
  logic [LANES-1:0] qm[$];
  logic [MASK_W-1:0] m_bm;
  int m_lsz;
  logic m_wr, m_busy = 1'b0, m_done = 1'b0;

  task automatic build();
    logic [AW-1:0] la, tmp;
    logic [LANES-1:0] lm;
    ql.delete(); qm.delete(); m_bm = '0;
    m_lsz = (space == 2'd1) ? TEXL : (space == 2'd0) ? 0 : CONSTL;
    m_wr = is_write;
    if (m_lsz == 0) return;
    for (int i = 0; i < LANES; i++) if (lane_active[i]) begin
      int p = 0; bit dup = 0;
      tmp = lane_addr[i*AW +: AW];
      la = tmp - (tmp % m_lsz);
      for (int k = 0; k < ql.size(); k++) begin
        if (ql[k] == la) dup = 1;
        else if (ql[k] < la) p = k + 1;
      end
      if (!dup) begin ql.insert(p, la); qm.insert(p, '0); end
      for (int b = 0; b < acc_size; b++) begin
        int idx = int'(tmp - la) + b;
        if (idx < MASK_W) m_bm[idx] = 1'b1;
      end
    end
    for (int i = 0; i < LANES; i++) if (lane_active[i]) begin
      tmp = lane_addr[i*AW +: AW];
      la = tmp - (tmp % m_lsz);
      for (int k = 0; k < ql.size(); k++) if (ql[k] == la) begin
        lm = qm[k]; lm[i] = 1'b1; qm[k] = lm;
      end
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy <= 1'b0; m_done <= 1'b0; ql.delete(); qm.delete();
    end else begin
      m_done <= 1'b0;
      if (m_busy) begin
        if (txn_ready) begin
          void'(ql.pop_front()); void'(qm.pop_front());
          if (ql.size() == 0) begin m_busy <= 1'b0; m_done <= 1'b1; end
        end
      end else if (start) begin
        build();
        if (ql.size() == 0) m_done <= 1'b1; else m_busy <= 1'b1;
      end
    end
  end

  task automatic chk(string what, logic [MASK_W-1:0] act, logic [MASK_W-1:0] exp);
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    vectors++;
    chk("busy", MASK_W'(busy), MASK_W'(m_busy));
    chk("done", MASK_W'(done), MASK_W'(m_done));
    chk("valid", MASK_W'(txn_valid), MASK_W'(m_busy));
    if (m_busy && ql.size() > 0) begin
      chk("line_addr", MASK_W'(txn_line_addr), MASK_W'(ql[0]));
      chk("lane_mask", MASK_W'(txn_lane_mask), MASK_W'(qm[0]));
      chk("byte_mask", txn_byte_mask, m_bm);
      chk("line_size", MASK_W'(txn_line_size), MASK_W'(m_lsz));
      chk("write", MASK_W'(txn_write), MASK_W'(m_wr));
    end
    txn_ready <= bp_en ? 1'($urandom_range(0, 1)) : 1'b1;
    if (cyc > 100000) begin
      miscompares++;
      $display("FAIL watchdog: actual cycle %0d expected under 100000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  logic [AW-1:0] a [LANES];

  task automatic run(string req, logic [LANES-1:0] act, logic [SZW-1:0] sz, logic [1:0] sp, logic wr);
    cur_req = req;
    @(negedge clk);
    lane_active = act; acc_size = sz; space = sp; is_write = wr;
    for (int i = 0; i < LANES; i++) lane_addr[i*AW +: AW] = a[i];
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (m_busy) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);                                       // R13 reset state compared every cycle
    for (int i = 0; i < LANES; i++) a[i] = 32'h1000 + 4 * i;
    run("R1", '1, 5'd4, 2'd1, 1'b0);                      // texture: two 64-byte lines
    run("R2", '1, 5'd4, 2'd2, 1'b1);                      // constant: four 32-byte lines
    for (int i = 0; i < LANES; i++) a[i] = 32'h2400 - 40 * i;
    run("R8", '1, 5'd8, 2'd3, 1'b0);                      // param space, descending addresses
    run("R3", '1, 5'd4, 2'd0, 1'b0);                      // zero line size
    run("R12", '0, 5'd4, 2'd1, 1'b0);                     // nothing active
    for (int i = 0; i < LANES; i++) a[i] = 32'h9000 + 64 * i;
    for (int i = 0; i < 4; i++) a[i] = 32'h500 + i;
    run("R4", 32'h0000_000F, 5'd1, 2'd1, 1'b0);           // inactive lanes own private lines
    for (int i = 0; i < LANES; i++) a[i] = 32'h3000 + 64 * (i % 3) + 60;
    run("R7", '1, 5'd16, 2'd1, 1'b1);                     // access crosses line end
    for (int i = 0; i < LANES; i++) a[i] = 32'h2400 - 40 * i;
    bp_en = 1'b1;
    run("R9", '1, 5'd8, 2'd2, 1'b0);                      // random stalls
    bp_en = 1'b0;
    cur_req = "R11";
    for (int i = 0; i < LANES; i++) a[i] = 32'h4000 + 32 * i;
    @(negedge clk);
    lane_active = '1; acc_size = 5'd4; space = 2'd2; is_write = 1'b0;
    for (int i = 0; i < LANES; i++) lane_addr[i*AW +: AW] = a[i];
    start = 1'b1;
    @(negedge clk);
    lane_active = 32'h1; space = 2'd1;
    for (int i = 0; i < LANES; i++) lane_addr[i*AW +: AW] = 32'hF000;
    @(negedge clk);
    start = 1'b0;
    while (m_busy) @(negedge clk);
    @(negedge clk);
    for (int t = 0; t < 40; t++) begin                    // R5 R6 random clusters
      for (int i = 0; i < LANES; i++) a[i] = 32'h8000 + $urandom_range(0, 511);
      bp_en = (t % 2) == 1;
      run((t % 2) ? "R6" : "R5", $urandom, SZW'($urandom_range(1, 16)),
          2'($urandom_range(1, 3)), 1'($urandom_range(0, 1)));
    end
    bp_en = 1'b0;
    cur_req = "R10";
    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule